// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block is the presentation stage for one processor. It keeps the processor's current priority and holds at most one interrupt offered by the sources. An offer is taken only when it is strictly more favoured than the current priority. Priorities are 8-bit values, and a numerically smaller value is more favoured. Any offer that is not taken is bounced straight back, so its source keeps it and tries again later.

Software acknowledges the held interrupt. The acknowledge returns the source number and the priority that was in force before it. It also raises the processor priority to the level of the interrupt being acknowledged. An end-of-interrupt may only move the priority towards less favoured values. A separate priority write can set any level, which lets software reopen its own level early. Every change of priority re-checks the held interrupt, and the held interrupt is evicted to its source once it no longer qualifies.

Top module: `intr_presenter`

## Requirements
- R1: After reset, irq_o is 0, cur_prio_o is 0xFF, and offer_rej_o, evict_valid_o and ack_valid_o are 0.
- R2: An offer is held, and irq_o is 1 from the next cycle, only when its priority is numerically less than the current priority. Otherwise offer_rej_o pulses in the next cycle.
- R3: Only one interrupt is held. An offer strictly more favoured than the held one replaces it, and the replaced source appears on evict_src_o with evict_valid_o in the next cycle. An offer that is equal or less favoured is rejected, and the held one stays.
- R4: An acknowledge while irq_o is 1 gives, in the next cycle, ack_valid_o=1, ack_src_o=held source and ack_prio_o=priority before the acknowledge. It also sets cur_prio_o to the held priority and clears the held slot.
- R5: An acknowledge while irq_o is 0 gives ack_src_o=0 (reserved "no interrupt") with ack_prio_o=current priority. The priority stays unchanged.
- R6: An EOI whose priority is numerically greater than or equal to the current priority loads it. An EOI with a smaller value is ignored.
- R7: A priority write loads any value into the current priority.
- R8: After a write or EOI, a held interrupt that is not strictly more favoured than the new priority is evicted in the next cycle (evict_valid_o, and irq_o drops). A held interrupt that still qualifies stays presented.
- R9: When several operations arrive in one cycle, acknowledge wins over priority write, and priority write wins over EOI. The losers have no effect.
- R10: An offer arriving in the same cycle as an acknowledge is judged against the priority set by that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| offer_valid_i | input | 1 | A source offers an interrupt this cycle |
| offer_src_i | input | SRC_W | Offered source number (nonzero) |
| offer_prio_i | input | PRIO_W | Offered priority |
| offer_rej_o | output | 1 | This cycle's offer from the previous cycle was refused |
| evict_valid_o | output | 1 | A held interrupt was returned to its source |
| evict_src_o | output | SRC_W | Source number returned |
| irq_o | output | 1 | Level interrupt to the processor while an offer is held |
| ack_i | input | 1 | Acknowledge (get interrupt) |
| ack_valid_o | output | 1 | Acknowledge response valid |
| ack_src_o | output | SRC_W | Acknowledged source, 0 when none |
| ack_prio_o | output | PRIO_W | Priority in force before the acknowledge |
| eoi_i | input | 1 | End of interrupt |
| eoi_prio_i | input | PRIO_W | Priority to restore on EOI |
| prio_wr_i | input | 1 | Direct priority write |
| prio_wr_data_i | input | PRIO_W | Value for the priority write |
| cur_prio_o | output | PRIO_W | Current processor priority |

## Verification
Every output is registered. The effect of an offer, acknowledge, EOI or write therefore shows up exactly one clock after the edge that samples it, and no output responds within the same cycle. The bench drives each operation for one cycle, starting at a falling edge. It compares all outputs at the next falling edge, which comes after the single rising edge that registers the result. This covers the pulses (offer_rej_o, evict_valid_o, ack_valid_o), which last one cycle only, and the new values of irq_o and cur_prio_o.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int unsigned NO_SRC = 0;

  // smaller value means more favoured
  function automatic logic beats(input logic [7:0] a, input logic [7:0] b);
    return a < b;
  endfunction
endpackage

// File: rtl/ipc_prio_reg.sv
module ipc_prio_reg #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  input  logic              held_v_i,
  input  logic [PRIO_W-1:0] held_prio_i,
  input  logic              wr_i,
  input  logic [PRIO_W-1:0] wr_data_i,
  input  logic              eoi_i,
  input  logic [PRIO_W-1:0] eoi_prio_i,
  output logic [PRIO_W-1:0] cur_q_o,
  output logic [PRIO_W-1:0] cur_nxt_o
);
  localparam logic [PRIO_W-1:0] LEAST = '1;

  always_comb begin
    cur_nxt_o = cur_q_o;
    if (ack_i) begin
      if (held_v_i) cur_nxt_o = held_prio_i;
    end else if (wr_i) begin
      cur_nxt_o = wr_data_i;
    end else if (eoi_i && (eoi_prio_i >= cur_q_o)) begin
      cur_nxt_o = eoi_prio_i;  // lowering only
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q_o <= LEAST;
    else         cur_q_o <= cur_nxt_o;
  end
endmodule

// File: rtl/ipc_slot.sv
module ipc_slot #(
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              offer_valid_i,
  input  logic [SRC_W-1:0]  offer_src_i,
  input  logic [PRIO_W-1:0] offer_prio_i,
  input  logic              ack_i,
  input  logic [PRIO_W-1:0] cur_nxt_i,
  output logic              held_v_o,
  output logic [SRC_W-1:0]  held_src_o,
  output logic [PRIO_W-1:0] held_prio_o,
  output logic              offer_rej_o,
  output logic              evict_valid_o,
  output logic [SRC_W-1:0]  evict_src_o
);
  logic still_held, keep, lost, take;

  assign still_held = held_v_o & ~ack_i;
  assign keep       = still_held & (held_prio_o < cur_nxt_i);
  assign lost       = still_held & ~(held_prio_o < cur_nxt_i);
  assign take       = offer_valid_i & (offer_prio_i < cur_nxt_i)
                    & (~keep | (offer_prio_i < held_prio_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_v_o      <= 1'b0;
      held_src_o    <= '0;
      held_prio_o   <= '1;
      offer_rej_o   <= 1'b0;
      evict_valid_o <= 1'b0;
      evict_src_o   <= '0;
    end else begin
      offer_rej_o   <= offer_valid_i & ~take;
      evict_valid_o <= lost | (keep & take);
      evict_src_o   <= (lost | (keep & take)) ? held_src_o : '0;
      if (take) begin
        held_v_o    <= 1'b1;
        held_src_o  <= offer_src_i;
        held_prio_o <= offer_prio_i;
      end else if (!keep) begin
        held_v_o    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter #(
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              offer_valid_i,
  input  logic [SRC_W-1:0]  offer_src_i,
  input  logic [PRIO_W-1:0] offer_prio_i,
  output logic              offer_rej_o,
  output logic              evict_valid_o,
  output logic [SRC_W-1:0]  evict_src_o,
  output logic              irq_o,
  input  logic              ack_i,
  output logic              ack_valid_o,
  output logic [SRC_W-1:0]  ack_src_o,
  output logic [PRIO_W-1:0] ack_prio_o,
  input  logic              eoi_i,
  input  logic [PRIO_W-1:0] eoi_prio_i,
  input  logic              prio_wr_i,
  input  logic [PRIO_W-1:0] prio_wr_data_i,
  output logic [PRIO_W-1:0] cur_prio_o
);
  localparam logic [SRC_W-1:0] NONE = SRC_W'(ipc_pkg::NO_SRC);

  logic              held_v;
  logic [SRC_W-1:0]  held_src;
  logic [PRIO_W-1:0] held_prio;
  logic [PRIO_W-1:0] cur_nxt;

  ipc_prio_reg #(.PRIO_W(PRIO_W)) u_prio (
    .clk_i, .rst_ni, .ack_i,
    .held_v_i(held_v), .held_prio_i(held_prio),
    .wr_i(prio_wr_i), .wr_data_i(prio_wr_data_i),
    .eoi_i, .eoi_prio_i,
    .cur_q_o(cur_prio_o), .cur_nxt_o(cur_nxt)
  );

  ipc_slot #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_slot (
    .clk_i, .rst_ni, .offer_valid_i, .offer_src_i, .offer_prio_i, .ack_i,
    .cur_nxt_i(cur_nxt),
    .held_v_o(held_v), .held_src_o(held_src), .held_prio_o(held_prio),
    .offer_rej_o, .evict_valid_o, .evict_src_o
  );

  assign irq_o = held_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_o <= 1'b0;
      ack_src_o   <= NONE;
      ack_prio_o  <= '0;
    end else begin
      ack_valid_o <= ack_i;
      if (ack_i) begin
        ack_src_o  <= held_v ? held_src : NONE;
        ack_prio_o <= cur_prio_o;
      end
    end
  end
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned PRIO_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              offer_valid_i,
  input logic              ack_i,
  input logic              eoi_i,
  input logic [PRIO_W-1:0] eoi_prio_i,
  input logic              prio_wr_i,
  input logic              irq_o,
  input logic              offer_rej_o,
  input logic              evict_valid_o,
  input logic              ack_valid_o,
  input logic [SRC_W-1:0]  ack_src_o,
  input logic [PRIO_W-1:0] ack_prio_o,
  input logic [PRIO_W-1:0] cur_prio_o,
  input logic [SRC_W-1:0]  held_src,
  input logic [PRIO_W-1:0] held_prio
);
  assert_rej_needs_offer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !offer_valid_i |=> !offer_rej_o);

  assert_held_qualifies_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (held_prio < cur_prio_o));

  assert_evict_had_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |=> !evict_valid_o);

  assert_ack_returns_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (ack_valid_o && ack_src_o == $past(held_src)
                          && ack_prio_o == $past(cur_prio_o)
                          && cur_prio_o == $past(held_prio)));

  assert_ack_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> (ack_src_o == '0 && $stable(cur_prio_o)));

  assert_eoi_no_raise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && !prio_wr_i && eoi_prio_i < cur_prio_o) |=> $stable(cur_prio_o));
endmodule

bind intr_presenter ipc_checker #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_chk (
  .clk_i, .rst_ni, .offer_valid_i, .ack_i, .eoi_i, .eoi_prio_i, .prio_wr_i,
  .irq_o, .offer_rej_o, .evict_valid_o, .ack_valid_o, .ack_src_o, .ack_prio_o,
  .cur_prio_o, .held_src(held_src), .held_prio(held_prio)
);

// File: tb/sim_intr_presenter.sv
module sim_intr_presenter;
  logic clk = 0, rst_ni = 0;
  always #2 clk = ~clk;

  logic       offer_valid_i = 0, ack_i = 0, eoi_i = 0, prio_wr_i = 0;
  logic [7:0] offer_src_i = 0, offer_prio_i = 0, eoi_prio_i = 0, prio_wr_data_i = 0;
  logic       offer_rej_o, evict_valid_o, irq_o, ack_valid_o;
  logic [7:0] evict_src_o, ack_src_o, ack_prio_o, cur_prio_o;

  intr_presenter u0 (
    .clk_i(clk), .rst_ni, .offer_valid_i, .offer_src_i, .offer_prio_i,
    .offer_rej_o, .evict_valid_o, .evict_src_o, .irq_o, .ack_i,
    .ack_valid_o, .ack_src_o, .ack_prio_o, .eoi_i, .eoi_prio_i,
    .prio_wr_i, .prio_wr_data_i, .cur_prio_o
  );

  int total = 0, bad = 0;
  bit done = 0;

  // op: 0 idle, 1 offer(a=src,b=prio), 2 ack, 3 eoi(b), 4 write(b)
  typedef struct packed {
    logic [2:0] op; logic [7:0] a; logic [7:0] b;
    logic irq; logic [7:0] cur; logic rej; logic ev; logic [7:0] evs;
    logic av; logic [7:0] as_; logic [7:0] ap; logic [7:0] req;
  } vec_t;

  localparam vec_t TBL [16] = '{
    '{3'd1, 8'd5, 8'h40, 1, 8'hFF, 0, 0, 8'd0, 0, 8'd0, 8'h00, 8'd2},  // R2 accept
    '{3'd1, 8'd7, 8'h40, 1, 8'hFF, 1, 0, 8'd0, 0, 8'd0, 8'h00, 8'd3},  // R3 tie refused
    '{3'd1, 8'd9, 8'h20, 1, 8'hFF, 0, 1, 8'd5, 0, 8'd0, 8'h00, 8'd3},  // R3 displace
    '{3'd2, 8'd0, 8'h00, 0, 8'h20, 0, 0, 8'd0, 1, 8'd9, 8'hFF, 8'd4},  // R4
    '{3'd1, 8'd3, 8'h20, 0, 8'h20, 1, 0, 8'd0, 0, 8'd0, 8'h00, 8'd2},  // R2 equal refused
    '{3'd1, 8'd3, 8'h10, 1, 8'h20, 0, 0, 8'd0, 0, 8'd0, 8'h00, 8'd2},
    '{3'd4, 8'd0, 8'h08, 0, 8'h08, 0, 1, 8'd3, 0, 8'd0, 8'h00, 8'd8},  // R8 write evicts
    '{3'd3, 8'd0, 8'h30, 0, 8'h30, 0, 0, 8'd0, 0, 8'd0, 8'h00, 8'd6},  // R6 lower ok
    '{3'd3, 8'd0, 8'h10, 0, 8'h30, 0, 0, 8'd0, 0, 8'd0, 8'h00, 8'd6},  // R6 raise ignored
    '{3'd1, 8'd4, 8'h2F, 1, 8'h30, 0, 0, 8'd0, 0, 8'd0, 8'h00, 8'd2},
    '{3'd4, 8'd0, 8'h2F, 0, 8'h2F, 0, 1, 8'd4, 0, 8'd0, 8'h00, 8'd8},  // R8 equal evicts
    '{3'd2, 8'd0, 8'h00, 0, 8'h2F, 0, 0, 8'd0, 1, 8'd0, 8'h2F, 8'd5},  // R5
    '{3'd3, 8'd0, 8'hFF, 0, 8'hFF, 0, 0, 8'd0, 0, 8'd0, 8'h00, 8'd6},
    '{3'd1, 8'd6, 8'h50, 1, 8'hFF, 0, 0, 8'd0, 0, 8'd0, 8'h00, 8'd2},
    '{3'd4, 8'd0, 8'h60, 1, 8'h60, 0, 0, 8'd0, 0, 8'd0, 8'h00, 8'd7},  // R7, R8 keep
    '{3'd2, 8'd0, 8'h00, 0, 8'h50, 0, 0, 8'd0, 1, 8'd6, 8'h60, 8'd4}
  };

  task automatic drive(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    offer_valid_i = (op == 1); offer_src_i = a; offer_prio_i = b;
    ack_i = (op == 2); eoi_i = (op == 3); eoi_prio_i = b;
    prio_wr_i = (op == 4); prio_wr_data_i = b;
  endtask

  task automatic idle_in();
    offer_valid_i = 0; ack_i = 0; eoi_i = 0; prio_wr_i = 0;
  endtask

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] pack_out();
    return {5'd0, irq_o, offer_rej_o, evict_valid_o, cur_prio_o, evict_src_o,
            7'd0, ack_valid_o, ack_src_o, ack_prio_o};
  endfunction

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", pack_out(), {5'd0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'd0, 7'd0, 1'b0, 8'd0, 8'd0});
    rst_ni = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      drive(TBL[i].op, TBL[i].a, TBL[i].b);
      @(negedge clk);
      idle_in();
      check($sformatf("R%0d row%0d", TBL[i].req, i), pack_out(),
            {5'd0, TBL[i].irq, TBL[i].rej, TBL[i].ev, TBL[i].cur, TBL[i].evs,
             7'd0, TBL[i].av, TBL[i].av ? TBL[i].as_ : ack_src_o,
             TBL[i].av ? TBL[i].ap : ack_prio_o});
    end

    // R9: ack beats write and EOI (cur 0x50)
    drive(1, 8'd2, 8'h40); @(negedge clk);
    drive(2, 0, 0); prio_wr_i = 1; prio_wr_data_i = 8'h05; eoi_i = 1; eoi_prio_i = 8'hF0;
    @(negedge clk); idle_in();
    check("R9 ack wins", {ack_valid_o, ack_src_o, ack_prio_o, cur_prio_o, irq_o},
          {1'b1, 8'd2, 8'h50, 8'h40, 1'b0});
    // R9: write beats EOI
    prio_wr_i = 1; prio_wr_data_i = 8'h70; eoi_i = 1; eoi_prio_i = 8'h90;
    @(negedge clk); idle_in();
    check("R9 write wins", {40'd0, cur_prio_o}, {40'd0, 8'h70});

    // R10: offer judged against priority set by same-cycle ack
    drive(1, 8'd1, 8'h38); @(negedge clk);
    drive(2, 0, 0); offer_valid_i = 1; offer_src_i = 8'd8; offer_prio_i = 8'h38;
    @(negedge clk); idle_in();
    check("R10 equal refused", {ack_src_o, cur_prio_o, offer_rej_o, irq_o},
          {8'd1, 8'h38, 1'b1, 1'b0});
    drive(2, 0, 0); offer_valid_i = 1; offer_src_i = 8'd8; offer_prio_i = 8'h30;
    @(negedge clk); idle_in();
    check("R10 better held", {ack_src_o, cur_prio_o, offer_rej_o, irq_o},
          {8'd0, 8'h38, 1'b0, 1'b1});

    // R1: reset mid-run clears held interrupt and priority
    rst_ni = 0; @(negedge clk);
    check("R1 rerun", {38'd0, irq_o, cur_prio_o, ack_valid_o},
          {38'd0, 1'b0, 8'hFF, 1'b0});
    rst_ni = 1; @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule